// File: doc/BRIEF.md
# Test Access Port Controller with Secondary-TAP Handoff

This block is the top-level boundary-scan test access port of a chip. It implements the sixteen-state TAP state machine, clocked by the test clock, and a 4-bit instruction register. Behind them sit three data registers: a 32-bit identification register, a one-bit bypass register, and a short boundary chain. The boundary chain has capture/shift cells on the pin inputs and the core outputs, plus update cells that can take over the pin outputs. The serial output changes on the falling test clock edge and has a separate output enable. Outside the shift states it rests at a fixed idle level.

One instruction hands the serial path to an embedded secondary TAP. While that instruction is active, the controller forwards the test mode select and the serial input to the secondary port and routes the secondary serial output to the pin. The controller itself stays parked in run-test/idle. The handoff ends only when the controller returns to test-logic-reset, either through the active-low test reset or through five consecutive test-mode-select highs. The secondary TAP's internal logic and the pad drivers lie outside this block.

Top module: `jtag_hnd_tap`

## Requirements
- R1: Test-logic-reset, whether it comes from the asynchronous low level of trst_n or from the state machine, loads the instruction register with code 0x1. That code selects the identification register.
- R2: The identification register captures a 32-bit value in Capture-DR. Bit 0 of that value is always 1 and bits 31:1 equal the parameter ID_UPPER. It shifts out least significant bit first.
- R3: The instruction register is 4 bits wide and is shifted least significant bit first. Capture-IR loads 4'b0001 (binary 01 in the two low bits, zeros above). A new code takes effect on the falling test clock edge in Update-IR.
- R4: Under code 0x2 (sample/preload), Capture-DR loads chain bits N_IN-1..0 from pin_in and chain bits N_IN+N_OUT-1..N_IN from sys_out. Chain bit 0 is the first bit on tdo.
- R5: Under code 0x2, pin_out follows sys_out, including after new values have been loaded into the update cells.
- R6: The update cells take the output part of the chain on the falling test clock edge in Update-DR, and only under code 0x0 or 0x2. Under any other code, a data scan leaves them unchanged.
- R7: Under code 0x0 (external drive) and code 0x3 (clamp), pin_out is driven from the update cells. Under any other code, pin_out equals sys_out.
- R8: Code 0x3, code 0xF and every unused code select the one-bit bypass register. This register captures 0, so tdo delivers a 0 first and then tdi delayed by one shift.
- R9: tdo changes on the falling test clock edge. tdo_oe is 1 only in Shift-IR or Shift-DR. Otherwise tdo is 0 and tdo_oe is 0 (unless R10 applies).
- R10: Under code 0x4, sec_en is 1, tdo equals sec_tdo, tdo_oe is 1, sec_tms equals tms and sec_tdi equals tdi. Without the handoff, sec_en is 0 and sec_tms is held at 1.
- R11: While code 0x4 is active, the controller stays in run-test/idle. A run of fewer than five tms highs leaves the handoff in place.
- R12: Five consecutive tms highs at rising test clock edges, or trst_n low, force test-logic-reset. This clears the handoff and restores code 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_in | input | N_IN | Pin-side input values seen by the input cells |
| sys_out | input | N_OUT | Core-side output values before the output cells |
| pin_out | output | N_OUT | Values delivered to the output pads |
| sec_en | output | 1 | Handoff active; enables the secondary TAP |
| sec_tms | output | 1 | Test mode select forwarded to the secondary TAP |
| sec_tdi | output | 1 | Serial data forwarded to the secondary TAP |
| sec_tdo | input | 1 | Serial data returned by the secondary TAP |

## Verification
The bench builds the block with N_IN = 4 and N_OUT = 4, which gives an 8-bit boundary chain. At that size it can sweep all 256 combinations of pin_in and sys_out through a sample capture. It can also sweep all 256 shift patterns through an external-drive scan and predict each captured word and each driven output arithmetically. The 32-bit identification word is a parameter the bench computes itself. The handoff is checked at the ports: a run of three tms highs must leave sec_en high, and five highs must drop it and bring the identification word back.

// File: rtl/jtag_hnd_pkg.sv
package jtag_hnd_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h2;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'h3;
  localparam logic [IR_W-1:0] OP_HANDOFF = 4'h4;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_e;

endpackage

// File: rtl/jtag_hnd_fsm.sv
module jtag_hnd_fsm
  import jtag_hnd_pkg::*;
#(
  parameter int RST_RUN = 5
) (
  input  logic       tclk,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       handoff,
  output tap_state_e state_q
);

  localparam int RW = $clog2(RST_RUN);

  logic [RW-1:0] run_q;
  tap_state_e    std_nxt;
  tap_state_e    nxt;

  always_comb begin
    unique case (state_q)
      ST_TLR:    std_nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    std_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: std_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: std_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: std_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: std_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: std_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: std_nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: std_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: std_nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: std_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: std_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: std_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: std_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: std_nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      default:   std_nxt = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  // forced reset on the last of RST_RUN highs, then the handoff park
  always_comb begin
    if (tms && run_q == RW'(RST_RUN - 1))               nxt = ST_TLR;
    else if (handoff && state_q == ST_RTI)              nxt = ST_RTI;
    else if (handoff && state_q == ST_UPD_IR)           nxt = ST_RTI;
    else                                                nxt = std_nxt;
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      state_q <= ST_TLR;
      run_q   <= '0;
    end else begin
      state_q <= nxt;
      if (!tms)                              run_q <= '0;
      else if (run_q != RW'(RST_RUN - 1))    run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/jtag_hnd_ir.sv
module jtag_hnd_ir
  import jtag_hnd_pkg::*;
(
  input  logic            tclk,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state_q,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q,
  output dr_sel_e         dr_sel,
  output logic            ext_drive,
  output logic            upd_en,
  output logic            handoff
);

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n)                    sr_q <= IR_W'(2'b01);
    else if (state_q == ST_CAP_IR)  sr_q <= IR_W'(2'b01);
    else if (state_q == ST_SHF_IR)  sr_q <= {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(negedge tclk or negedge trst_n) begin
    if (!trst_n)                    ir_q <= OP_IDCODE;
    else if (state_q == ST_TLR)     ir_q <= OP_IDCODE;
    else if (state_q == ST_UPD_IR)  ir_q <= sr_q;
  end

  always_comb begin
    unique case (ir_q)
      OP_EXTEST, OP_SAMPLE: dr_sel = DR_BSR;
      OP_IDCODE:            dr_sel = DR_ID;
      default:              dr_sel = DR_BYP;
    endcase
  end

  assign ir_so     = sr_q[0];
  assign ext_drive = (ir_q == OP_EXTEST) || (ir_q == OP_CLAMP);
  assign upd_en    = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);
  assign handoff   = (ir_q == OP_HANDOFF);

endmodule

// File: rtl/jtag_hnd_bsr.sv
module jtag_hnd_bsr
  import jtag_hnd_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tclk,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_state_e       state_q,
  input  logic             sel,
  input  logic             upd_en,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] sys_out,
  output logic             so,
  output logic [N_OUT-1:0] upd_q
);

  localparam int L = N_IN + N_OUT;

  logic [L-1:0] sr_q;
  logic [L-1:0] cap;
  logic [L-1:0] shin;

  assign cap  = {sys_out, pin_in};
  assign shin = {tdi, sr_q[L-1:1]};
  assign so   = sr_q[0];

  for (genvar g = 0; g < L; g++) begin : g_cell
    always_ff @(posedge tclk or negedge trst_n) begin
      if (!trst_n)                          sr_q[g] <= 1'b0;
      else if (sel && state_q == ST_CAP_DR) sr_q[g] <= cap[g];
      else if (sel && state_q == ST_SHF_DR) sr_q[g] <= shin[g];
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_upd
    always_ff @(negedge tclk or negedge trst_n) begin
      if (!trst_n)                             upd_q[g] <= 1'b0;
      else if (upd_en && state_q == ST_UPD_DR) upd_q[g] <= sr_q[N_IN + g];
    end
  end

endmodule

// File: rtl/jtag_hnd_tap.sv
module jtag_hnd_tap
  import jtag_hnd_pkg::*;
#(
  parameter int          N_IN     = 4,
  parameter int          N_OUT    = 4,
  parameter int          ID_W     = 32,
  parameter logic [30:0] ID_UPPER = 31'h0D96701F,
  parameter logic        TDO_IDLE = 1'b0
) (
  input  logic             tclk,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] sys_out,
  output logic [N_OUT-1:0] pin_out,
  output logic             sec_en,
  output logic             sec_tms,
  output logic             sec_tdi,
  input  logic             sec_tdo
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_UPPER[ID_W-2:0], 1'b1};

  tap_state_e       state_q;
  logic [IR_W-1:0]  ir_q;
  dr_sel_e          dr_sel;
  logic             ir_so, bsr_so, ext_drive, upd_en, handoff;
  logic [N_OUT-1:0] upd_q;
  logic [ID_W-1:0]  id_sr;
  logic             byp_q;
  logic             dr_so;
  logic             tdo_q, oe_q;

  jtag_hnd_fsm #(.RST_RUN(5)) u_fsm (
    .tclk(tclk), .trst_n(trst_n), .tms(tms), .handoff(handoff), .state_q(state_q)
  );

  jtag_hnd_ir u_ir (
    .tclk(tclk), .trst_n(trst_n), .tdi(tdi), .state_q(state_q), .ir_so(ir_so),
    .ir_q(ir_q), .dr_sel(dr_sel), .ext_drive(ext_drive), .upd_en(upd_en),
    .handoff(handoff)
  );

  jtag_hnd_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .tclk(tclk), .trst_n(trst_n), .tdi(tdi), .state_q(state_q),
    .sel(dr_sel == DR_BSR), .upd_en(upd_en), .pin_in(pin_in),
    .sys_out(sys_out), .so(bsr_so), .upd_q(upd_q)
  );

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      if (dr_sel == DR_ID && state_q == ST_CAP_DR)      id_sr <= ID_WORD;
      else if (dr_sel == DR_ID && state_q == ST_SHF_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
      if (dr_sel == DR_BYP && state_q == ST_CAP_DR)      byp_q <= 1'b0;
      else if (dr_sel == DR_BYP && state_q == ST_SHF_DR) byp_q <= tdi;
    end
  end

  always_comb begin
    unique case (dr_sel)
      DR_ID:   dr_so = id_sr[0];
      DR_BSR:  dr_so = bsr_so;
      default: dr_so = byp_q;
    endcase
  end

  always_ff @(negedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= TDO_IDLE;
      oe_q  <= 1'b0;
    end else if (state_q == ST_SHF_IR) begin
      tdo_q <= ir_so;
      oe_q  <= 1'b1;
    end else if (state_q == ST_SHF_DR) begin
      tdo_q <= dr_so;
      oe_q  <= 1'b1;
    end else begin
      tdo_q <= TDO_IDLE;
      oe_q  <= 1'b0;
    end
  end

  assign tdo     = handoff ? sec_tdo : tdo_q;
  assign tdo_oe  = handoff | oe_q;
  assign pin_out = ext_drive ? upd_q : sys_out;
  assign sec_en  = handoff;
  assign sec_tms = handoff ? tms : 1'b1;
  assign sec_tdi = tdi;

endmodule

// File: rtl/jtag_hnd_chk.sv
module jtag_hnd_chk
  import jtag_hnd_pkg::*;
#(
  parameter int   N_OUT    = 4,
  parameter int   ID_W     = 32,
  parameter logic TDO_IDLE = 1'b0
) (
  input logic             tclk,
  input logic             trst_n,
  input logic             tms,
  input tap_state_e       state_q,
  input logic [IR_W-1:0]  ir_q,
  input logic             tdo,
  input logic             tdo_oe,
  input logic             sec_en,
  input logic             sec_tdo,
  input logic [N_OUT-1:0] upd_q,
  input logic [N_OUT-1:0] pin_out,
  input logic [ID_W-1:0]  id_sr
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n)      hi_cnt <= '0;
    else if (!tms)    hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  p_idcode_default_r1: assert property (@(posedge tclk) disable iff (!trst_n)
    $past(state_q == ST_TLR) |-> ir_q == OP_IDCODE);

  p_id_lsb_r2: assert property (@(posedge tclk) disable iff (!trst_n)
    (state_q == ST_CAP_DR && ir_q == OP_IDCODE) |=> id_sr[0]);

  p_upd_stable_r6: assert property (@(posedge tclk) disable iff (!trst_n)
    (state_q != ST_UPD_DR) |-> $stable(upd_q));

  p_drive_from_upd_r7: assert property (@(posedge tclk) disable iff (!trst_n)
    (ir_q == OP_EXTEST || ir_q == OP_CLAMP) |-> pin_out == upd_q);

  p_oe_window_r9: assert property (@(posedge tclk) disable iff (!trst_n)
    !sec_en |-> tdo_oe == (state_q == ST_SHF_IR || state_q == ST_SHF_DR));

  p_idle_level_r9: assert property (@(posedge tclk) disable iff (!trst_n)
    !tdo_oe |-> tdo == TDO_IDLE);

  p_sec_path_r10: assert property (@(posedge tclk) disable iff (!trst_n)
    sec_en |-> (tdo == sec_tdo && tdo_oe));

  p_hold_rti_r11: assert property (@(posedge tclk) disable iff (!trst_n)
    (sec_en && state_q == ST_RTI) |=> (state_q == ST_RTI || state_q == ST_TLR));

  p_five_high_r12: assert property (@(posedge tclk) disable iff (!trst_n)
    (hi_cnt >= 3'd5) |-> state_q == ST_TLR);

endmodule

bind jtag_hnd_tap jtag_hnd_chk #(.N_OUT(N_OUT), .ID_W(ID_W), .TDO_IDLE(TDO_IDLE)) u_chk (
  .tclk(tclk), .trst_n(trst_n), .tms(tms), .state_q(state_q), .ir_q(ir_q),
  .tdo(tdo), .tdo_oe(tdo_oe), .sec_en(sec_en), .sec_tdo(sec_tdo),
  .upd_q(upd_q), .pin_out(pin_out), .id_sr(id_sr)
);

// File: tb/tb_jtag_hnd_tap.sv
module tb_jtag_hnd_tap;

  localparam int          PER   = 20;
  localparam int          NI    = 4;
  localparam int          NO    = 4;
  localparam logic [30:0] IDU   = 31'h0D96701F;
  localparam int          WD    = 150000;

  logic tclk = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, sec_tdo = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] sys_out = '0;
  logic tdo, tdo_oe, sec_en, sec_tms, sec_tdi;
  logic [NO-1:0] pin_out;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic smp, smp_oe;

  jtag_hnd_tap #(.N_IN(NI), .N_OUT(NO), .ID_W(32), .ID_UPPER(IDU), .TDO_IDLE(1'b0)) dut (
    .tclk(tclk), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .sys_out(sys_out), .pin_out(pin_out), .sec_en(sec_en),
    .sec_tms(sec_tms), .sec_tdi(sec_tdi), .sec_tdo(sec_tdo)
  );

  always #(PER/2) tclk = ~tclk;

  always @(posedge tclk) begin
    cyc++;
    if (cyc == WD) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // sample tdo for the current state, then drive the inputs for the next rising edge
  task automatic step(input logic m, input logic d);
    @(negedge tclk); #1;
    smp = tdo; smp_oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i]); cap[i] = smp;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout, output bit oe_ok);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    oe_ok = !smp_oe;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]); dout[i] = smp;
      oe_ok = oe_ok && smp_oe;
    end
    step(1, 0); oe_ok = oe_ok && !smp_oe;
    step(0, 0);
  endtask

  initial begin
    logic [3:0] cap;
    logic [31:0] dout;
    logic [7:0] last_v;
    bit oe_ok;

    repeat (3) @(posedge tclk);
    @(negedge tclk); #1 trst_n = 1'b1;
    step(0, 0);
    step(0, 0);
    check(tdo_oe == 1'b0 && tdo == 1'b0, "R9 idle after reset", {tdo_oe, tdo}, 0);
    check(sec_en == 1'b0 && sec_tms == 1'b1, "R10 no handoff after reset", {sec_en, sec_tms}, 1);

    // R1 / R2: identification word selected straight from reset
    scan_dr(32, 32'h0, dout, oe_ok);
    check(dout == {IDU, 1'b1}, "R1 IDCODE selected after reset", dout, {IDU, 1'b1});
    check(dout[0] == 1'b1, "R2 id bit0 is one", dout[0], 1);
    check(oe_ok, "R9 oe only during Shift-DR", oe_ok, 1);

    // R3: capture pattern of the instruction register
    scan_ir(4'h1, cap);
    check(cap == 4'b0001, "R3 Capture-IR pattern", cap, 4'b0001);

    // R4 / R5: sample every pin_in x sys_out combination
    scan_ir(4'h2, cap);
    for (int v = 0; v < 256; v++) begin
      pin_in = v[3:0]; sys_out = v[7:4];
      scan_dr(8, 32'(8'h5A ^ v[7:0]), dout, oe_ok);
      check(dout[7:0] == v[7:0], "R4 sample capture", dout[7:0], v[7:0]);
      check(pin_out == sys_out, "R5 sample leaves outputs alone", pin_out, sys_out);
    end

    // preload A5: output cells take 4'hA
    sys_out = 4'h3;
    scan_dr(8, 32'hA5, dout, oe_ok);
    check(pin_out == 4'h3, "R5 preload not driven", pin_out, 4'h3);
    scan_ir(4'h0, cap);
    check(pin_out == 4'hA, "R7 EXTEST drives preloaded value", pin_out, 4'hA);

    // R6 / R7: external drive sweep over every shift pattern
    for (int v = 0; v < 256; v++) begin
      pin_in = 4'(v * 3); sys_out = 4'(v + 5);
      scan_dr(8, 32'(v), dout, oe_ok);
      check(dout[7:0] == {4'(v + 5), 4'(v * 3)}, "R4 capture under EXTEST",
            dout[7:0], {4'(v + 5), 4'(v * 3)});
      check(pin_out == v[7:4], "R7 EXTEST update drives pins", pin_out, v[7:4]);
    end
    last_v = 8'hFF;
    sys_out = 4'h6;
    check(pin_out == last_v[7:4], "R7 sys_out ignored under EXTEST", pin_out, last_v[7:4]);

    // R6: identification scan does not touch the update cells
    scan_ir(4'h1, cap);
    check(pin_out == 4'h6, "R7 pins follow core under IDCODE", pin_out, 4'h6);
    scan_dr(32, 32'h0000_0000, dout, oe_ok);
    scan_ir(4'h3, cap);
    check(pin_out == last_v[7:4], "R6 update cells kept through IDCODE scan", pin_out, last_v[7:4]);

    // R8: clamp selects the bypass bit
    scan_dr(8, 32'h96, dout, oe_ok);
    check(dout[7:0] == 8'h2C, "R8 clamp bypass delay", dout[7:0], 8'h2C);
    check(pin_out == last_v[7:4], "R6 clamp scan keeps update cells", pin_out, last_v[7:4]);

    scan_ir(4'hF, cap);
    scan_dr(8, 32'h3B, dout, oe_ok);
    check(dout[7:0] == 8'h76, "R8 bypass code 0xF", dout[7:0], 8'h76);
    scan_ir(4'h7, cap);
    scan_dr(8, 32'hC1, dout, oe_ok);
    check(dout[7:0] == 8'h82, "R8 unused code 0x7 bypass", dout[7:0], 8'h82);
    check(pin_out == 4'h6, "R7 pins follow core under bypass", pin_out, 4'h6);

    // R10 / R11 / R12: handoff to the secondary TAP
    scan_ir(4'h4, cap);
    check(sec_en == 1'b1, "R10 handoff enable", sec_en, 1);
    sec_tdo = 1'b1; #1;
    check(tdo == 1'b1 && tdo_oe == 1'b1, "R10 tdo routed high", {tdo_oe, tdo}, 2'b11);
    sec_tdo = 1'b0; #1;
    check(tdo == 1'b0 && tdo_oe == 1'b1, "R10 tdo routed low", {tdo_oe, tdo}, 2'b10);
    tms = 1'b1; tdi = 1'b1; #1;
    check(sec_tms == 1'b1 && sec_tdi == 1'b1, "R10 tms/tdi forwarded high", {sec_tms, sec_tdi}, 2'b11);
    tms = 1'b0; tdi = 1'b0; #1;
    check(sec_tms == 1'b0 && sec_tdi == 1'b0, "R10 tms/tdi forwarded low", {sec_tms, sec_tdi}, 0);
    step(1, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check(sec_en == 1'b1, "R11 three highs keep handoff", sec_en, 1);
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    check(sec_en == 1'b1, "R11 DR-scan pattern keeps handoff", sec_en, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0); step(0, 0);
    check(sec_en == 1'b0 && sec_tms == 1'b1, "R12 five highs release handoff", {sec_en, sec_tms}, 1);
    scan_dr(32, 32'h0, dout, oe_ok);
    check(dout == {IDU, 1'b1}, "R12 IDCODE restored", dout, {IDU, 1'b1});

    scan_ir(4'h4, cap);
    check(sec_en == 1'b1, "R10 second handoff", sec_en, 1);
    @(negedge tclk); #1 trst_n = 1'b0;
    #2;
    check(sec_en == 1'b0 && tdo_oe == 1'b0, "R12 trst releases handoff", {sec_en, tdo_oe}, 0);
    @(negedge tclk); #1 trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 32'h0, dout, oe_ok);
    check(dout == {IDU, 1'b1}, "R1 IDCODE after trst", dout, {IDU, 1'b1});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule